// File: doc/BRIEF.md
# Store Queue with Head Reissue

This block keeps stores that are in flight in age order and carries each one through three steps: commit, writeback to a data cache, and in-order retirement. A store enters with a sequence number, an address and data, and receives the slot index it was written to. A commit input names the youngest committed sequence number. The queue then walks its entries from oldest to youngest and enables writeback for the ones that qualify. Enabled stores go to the cache oldest first over a valid/ready request port. Completions come back on a response port, tagged with the slot index, and they may arrive in any order.

The distinctive rule covers a completion for the entry at the head of the queue. It does not retire that entry at once. Instead the same write goes to the cache a second time, and the entry retires only when the second completion arrives. A completion for a younger entry only marks that entry as completed. The second send for it happens once it becomes the head. A squash removes uncommitted stores that are younger than a given sequence number. Committed stores survive a squash.

Top module: `store_queue`

## Requirements
- R1: A store is written to slot `allocIdx` when `allocValid` is high, `full` is low and `squashValid` is low, and `occupancy` then rises by one. `allocIdx` is (head + occupancy) mod depth. `full` is high exactly when occupancy equals the depth (4), and an allocation while full changes nothing.
- R2: A commit update happens only in a cycle where `commitSeq` is nonzero and `squashValid` is low.
- R3: A commit update walks the entries from oldest to youngest. Each entry that is not yet writeback-enabled and has a sequence number no greater than `commitSeq` becomes enabled. The walk stops at the first non-enabled entry with a larger sequence number. Entries already enabled are skipped and are not counted again.
- R4: `pendWb` counts enabled stores whose first request has not been accepted. It rises by the number of entries newly enabled and falls by one when a first request (`reqReissue`=0) is accepted. An accepted second send leaves it unchanged.
- R5: First requests go out for enabled entries in age order. Each request is registered, so it appears on `reqValid`/`reqIdx`/`reqAddr`/`reqData` one cycle after the entry becomes eligible, with `reqReissue`=0.
- R6: While `reqValid` is high and `reqReady` is low, the request stays exactly as it is. No other store is offered until it is accepted.
- R7: A response (`respValid`, `respIdx`) for an entry that is not the head only marks that entry completed. It produces no request and no retirement. Two cycles after that entry becomes the head, its second send appears with `reqReissue`=1.
- R8: A response for the head entry before its second send clears its completed state. The same address and data are offered again with `reqReissue`=1 two cycles later, and this second send wins over any pending first request.
- R9: A response for the head entry after its second send was accepted retires it in the same cycle: `retireValid` goes high with `retireSeq` equal to its sequence number, and occupancy falls by one at the next edge.
- R10: When `squashValid` is high, every entry that is not writeback-enabled and has a sequence number greater than `squashSeq` is removed from the young end of the queue. Enabled entries remain, and allocation and commit are ignored in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate a new store |
| allocSeq | input | 8 | Sequence number of the new store |
| allocAddr | input | ADDR_W | Address of the new store |
| allocData | input | DATA_W | Data of the new store |
| allocIdx | output | 2 | Slot the next allocation goes to |
| full | output | 1 | All slots occupied |
| commitSeq | input | 8 | Youngest committed sequence number, 0 = none |
| squashValid | input | 1 | Squash in progress this cycle |
| squashSeq | input | 8 | Squash boundary sequence number |
| reqValid | output | 1 | Cache write request valid |
| reqReady | input | 1 | Cache accepts the request |
| reqIdx | output | 2 | Slot of the requested store |
| reqReissue | output | 1 | Request is the second send of a head entry |
| reqAddr | output | ADDR_W | Request address |
| reqData | output | DATA_W | Request data |
| respValid | input | 1 | Cache completion valid |
| respIdx | input | 2 | Slot the completion belongs to |
| retireValid | output | 1 | Head store retires this cycle |
| retireSeq | output | 8 | Sequence number of the retiring store |
| occupancy | output | 3 | Number of occupied slots |
| pendWb | output | 3 | Enabled stores not yet sent |

## Verification
The bench fills all four slots, then tries a commit and an allocation in cycles where they must be refused. It holds a request blocked for several cycles, and a design that moved on would show a new `reqIdx` or drop `reqValid` early. Responses are returned out of order so that a younger store completes before the head. A design that retired or resent that store early would show `retireValid` or a `reqReissue` request too soon. A head completion is made to coincide with a new commit, which exposes a design that lets the first send of the younger store win over the second send of the head. Squashes are run with a mix of committed and uncommitted entries across a wrapped head pointer, and a design that dropped committed stores, or kept young uncommitted ones, shows the wrong `occupancy` and `allocIdx`.

// File: rtl/stq_pkg.sv
package stq_pkg;
  localparam int SQ_DEPTH = 4;
  localparam int SQ_IDX_W = $clog2(SQ_DEPTH);
  localparam int SQ_CNT_W = SQ_IDX_W + 1;
  localparam int SQ_SEQ_W = 8;

  typedef logic [SQ_IDX_W-1:0] sqIdx_t;
  typedef logic [SQ_SEQ_W-1:0] sqSeq_t;

  // Strobes from control to the entry storage
  typedef struct packed {
    logic                allocEn;
    sqIdx_t              allocIdx;
    logic [SQ_DEPTH-1:0] markVec;
    logic                firstAccEn;
    sqIdx_t              firstAccIdx;
    logic                reissAccEn;
    logic                setComplEn;
    sqIdx_t              setComplIdx;
    logic                headToReiss;
    logic                retireEn;
    sqIdx_t              headIdx;
  } sqStrobe_t;
endpackage

// File: rtl/stq_datapath.sv
module stq_datapath
  import stq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  sqStrobe_t                  strobe,
  input  sqSeq_t                     allocSeq,
  input  logic [ADDR_W-1:0]          allocAddr,
  input  logic [DATA_W-1:0]          allocData,
  input  sqIdx_t                     rdIdx,
  output logic [ADDR_W-1:0]          rdAddr,
  output logic [DATA_W-1:0]          rdData,
  output sqSeq_t [SQ_DEPTH-1:0]      seqArr,
  output logic [SQ_DEPTH-1:0]        wbEnVec,
  output logic [SQ_DEPTH-1:0]        sentVec,
  output logic [SQ_DEPTH-1:0]        complVec,
  output logic [SQ_DEPTH-1:0]        reissVec,
  output logic [SQ_DEPTH-1:0]        needVec
);
  logic [ADDR_W-1:0] addrMem [SQ_DEPTH];
  logic [DATA_W-1:0] dataMem [SQ_DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.allocEn) begin
      seqArr[strobe.allocIdx]  <= allocSeq;
      addrMem[strobe.allocIdx] <= allocAddr;
      dataMem[strobe.allocIdx] <= allocData;
    end
  end

  assign rdAddr = addrMem[rdIdx];
  assign rdData = dataMem[rdIdx];

  for (genvar i = 0; i < SQ_DEPTH; i++) begin : gEntry
    logic wbEnQ, sentQ, complQ, reissQ, needQ;
    logic hitAlloc, hitHead;
    assign hitAlloc = strobe.allocEn && (strobe.allocIdx == SQ_IDX_W'(i));
    assign hitHead  = (strobe.headIdx == SQ_IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN || hitAlloc || (strobe.retireEn && hitHead)) begin
        wbEnQ  <= 1'b0;
        sentQ  <= 1'b0;
        complQ <= 1'b0;
        reissQ <= 1'b0;
        needQ  <= 1'b0;
      end else begin
        if (strobe.markVec[i]) wbEnQ <= 1'b1;
        if (strobe.firstAccEn && strobe.firstAccIdx == SQ_IDX_W'(i)) sentQ <= 1'b1;
        if (strobe.reissAccEn && hitHead) begin
          reissQ <= 1'b1;
          needQ  <= 1'b0;
        end
        if (strobe.setComplEn && strobe.setComplIdx == SQ_IDX_W'(i)) complQ <= 1'b1;
        if (strobe.headToReiss && hitHead) begin
          complQ <= 1'b0;
          needQ  <= 1'b1;
        end
      end
    end

    assign wbEnVec[i]  = wbEnQ;
    assign sentVec[i]  = sentQ;
    assign complVec[i] = complQ;
    assign reissVec[i] = reissQ;
    assign needVec[i]  = needQ;
  end

  // R8: at most one entry (the head) has completed its second send
  a_r8_single_reissued: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reissVec));
  // R5: nothing is sent before its writeback is enabled
  a_r5_sent_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (sentVec & ~wbEnVec) == '0);
  // R7: a reissued entry never carries a stale completed flag
  a_r7_no_stale_complete: assert property (@(posedge clk) disable iff (!rstN)
    (complVec & reissVec) == '0);
endmodule

// File: rtl/stq_control.sv
module stq_control
  import stq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  allocValid,
  input  sqSeq_t                commitSeq,
  input  logic                  squashValid,
  input  sqSeq_t                squashSeq,
  input  logic                  reqReady,
  input  logic                  respValid,
  input  sqIdx_t                respIdx,
  input  sqSeq_t [SQ_DEPTH-1:0] seqArr,
  input  logic [SQ_DEPTH-1:0]   wbEnVec,
  input  logic [SQ_DEPTH-1:0]   sentVec,
  input  logic [SQ_DEPTH-1:0]   complVec,
  input  logic [SQ_DEPTH-1:0]   reissVec,
  input  logic [SQ_DEPTH-1:0]   needVec,
  output sqStrobe_t             strobe,
  output logic                  full,
  output sqIdx_t                allocIdx,
  output logic [SQ_CNT_W-1:0]   occupancy,
  output logic [SQ_CNT_W-1:0]   pendWb,
  output logic                  reqValid,
  output sqIdx_t                reqIdx,
  output logic                  reqReissue,
  output logic                  retireValid,
  output sqSeq_t                retireSeq
);
  logic [SQ_CNT_W-1:0] cntQ, cntN, pendQ, keepCnt;
  sqIdx_t              headQ;
  logic                reqValidQ, reqReissQ;
  sqIdx_t              reqIdxQ;

  logic                commitGo, allocEn, acceptNow, reqFree;
  logic [SQ_DEPTH-1:0] markVec;
  logic                stopC, stopS, firstFound, reissNeed;
  sqIdx_t              walkSlot, keepSlot, pickSlot, firstIdx;
  logic                headLive, respHead, headDone, retireEn, headToReiss;

  assign full     = (cntQ == SQ_CNT_W'(SQ_DEPTH));
  assign allocIdx = headQ + cntQ[SQ_IDX_W-1:0];
  assign commitGo = (commitSeq != '0) && !squashValid;
  assign allocEn  = allocValid && !full && !squashValid;
  assign acceptNow = reqValidQ && reqReady;
  assign reqFree   = !reqValidQ || reqReady;

  // Commit walk, oldest first
  always_comb begin
    markVec  = '0;
    stopC    = 1'b0;
    walkSlot = headQ;
    for (int k = 0; k < SQ_DEPTH; k++) begin
      walkSlot = headQ + SQ_IDX_W'(k);
      if (commitGo && !stopC && (k < int'(cntQ)) && !wbEnVec[walkSlot]) begin
        if (seqArr[walkSlot] > commitSeq) stopC = 1'b1;
        else markVec[walkSlot] = 1'b1;
      end
    end
  end

  // Squash: count the surviving prefix
  always_comb begin
    keepCnt  = '0;
    stopS    = 1'b0;
    keepSlot = headQ;
    for (int k = 0; k < SQ_DEPTH; k++) begin
      keepSlot = headQ + SQ_IDX_W'(k);
      if (!stopS && (k < int'(cntQ))) begin
        if (wbEnVec[keepSlot] || seqArr[keepSlot] <= squashSeq)
          keepCnt = keepCnt + SQ_CNT_W'(1);
        else
          stopS = 1'b1;
      end
    end
  end

  // Oldest enabled store still waiting for its first send
  always_comb begin
    firstFound = 1'b0;
    firstIdx   = '0;
    pickSlot   = headQ;
    for (int k = 0; k < SQ_DEPTH; k++) begin
      pickSlot = headQ + SQ_IDX_W'(k);
      if (!firstFound && (k < int'(cntQ)) && wbEnVec[pickSlot] && !sentVec[pickSlot]
          && !(acceptNow && !reqReissQ && reqIdxQ == pickSlot)) begin
        firstFound = 1'b1;
        firstIdx   = pickSlot;
      end
    end
  end

  assign reissNeed   = headLive && needVec[headQ] && !(acceptNow && reqReissQ);
  assign headLive    = (cntQ != '0);
  assign respHead    = respValid && headLive && (respIdx == headQ);
  assign headDone    = headLive && (complVec[headQ] || respHead);
  assign retireEn    = headDone && reissVec[headQ];
  assign headToReiss = headDone && !reissVec[headQ];

  always_comb begin
    if (squashValid) cntN = keepCnt - SQ_CNT_W'(retireEn);
    else             cntN = cntQ + SQ_CNT_W'(allocEn) - SQ_CNT_W'(retireEn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ      <= '0;
      headQ     <= '0;
      pendQ     <= '0;
      reqValidQ <= 1'b0;
      reqIdxQ   <= '0;
      reqReissQ <= 1'b0;
    end else begin
      cntQ  <= cntN;
      headQ <= headQ + SQ_IDX_W'(retireEn);
      pendQ <= pendQ + SQ_CNT_W'($countones(markVec))
                     - SQ_CNT_W'(acceptNow && !reqReissQ);
      if (reqFree) begin
        if (reissNeed) begin
          reqValidQ <= 1'b1;
          reqIdxQ   <= headQ;
          reqReissQ <= 1'b1;
        end else if (firstFound) begin
          reqValidQ <= 1'b1;
          reqIdxQ   <= firstIdx;
          reqReissQ <= 1'b0;
        end else begin
          reqValidQ <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.allocEn     = allocEn;
    strobe.allocIdx    = allocIdx;
    strobe.markVec     = markVec;
    strobe.firstAccEn  = acceptNow && !reqReissQ;
    strobe.firstAccIdx = reqIdxQ;
    strobe.reissAccEn  = acceptNow && reqReissQ;
    strobe.setComplEn  = respValid && !respHead;
    strobe.setComplIdx = respIdx;
    strobe.headToReiss = headToReiss;
    strobe.retireEn    = retireEn;
    strobe.headIdx     = headQ;
  end

  assign occupancy   = cntQ;
  assign pendWb      = pendQ;
  assign reqValid    = reqValidQ;
  assign reqIdx      = reqIdxQ;
  assign reqReissue  = reqReissQ;
  assign retireValid = retireEn;
  assign retireSeq   = seqArr[headQ];

  // R1: occupancy never exceeds the depth
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(cntQ) <= SQ_DEPTH);
  // R4: counter agrees with the per-entry flags
  a_r4_pend_matches_flags: assert property (@(posedge clk) disable iff (!rstN)
    int'(pendQ) == $countones(wbEnVec & ~sentVec));
  // R6: a blocked request is held unchanged
  a_r6_hold_blocked: assert property (@(posedge clk) disable iff (!rstN)
    reqValidQ && !reqReady |=> reqValidQ && $stable(reqIdxQ) && $stable(reqReissQ));
  // R8: a second send always targets the head
  a_r8_reissue_at_head: assert property (@(posedge clk) disable iff (!rstN)
    reqValidQ && reqReissQ |-> reqIdxQ == headQ);
  // R5: only enabled stores are requested
  a_r5_req_enabled: assert property (@(posedge clk) disable iff (!rstN)
    reqValidQ |-> wbEnVec[reqIdxQ]);
endmodule

// File: rtl/store_queue.sv
module store_queue
  import stq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                allocValid,
  input  logic [SQ_SEQ_W-1:0] allocSeq,
  input  logic [ADDR_W-1:0]   allocAddr,
  input  logic [DATA_W-1:0]   allocData,
  output logic [SQ_IDX_W-1:0] allocIdx,
  output logic                full,
  input  logic [SQ_SEQ_W-1:0] commitSeq,
  input  logic                squashValid,
  input  logic [SQ_SEQ_W-1:0] squashSeq,
  output logic                reqValid,
  input  logic                reqReady,
  output logic [SQ_IDX_W-1:0] reqIdx,
  output logic                reqReissue,
  output logic [ADDR_W-1:0]   reqAddr,
  output logic [DATA_W-1:0]   reqData,
  input  logic                respValid,
  input  logic [SQ_IDX_W-1:0] respIdx,
  output logic                retireValid,
  output logic [SQ_SEQ_W-1:0] retireSeq,
  output logic [SQ_CNT_W-1:0] occupancy,
  output logic [SQ_CNT_W-1:0] pendWb
);
  sqStrobe_t             strobe;
  sqSeq_t [SQ_DEPTH-1:0] seqArr;
  logic [SQ_DEPTH-1:0]   wbEnVec, sentVec, complVec, reissVec, needVec;

  stq_control uCtrl (
    .clk, .rstN, .allocValid, .commitSeq, .squashValid, .squashSeq,
    .reqReady, .respValid, .respIdx, .seqArr,
    .wbEnVec, .sentVec, .complVec, .reissVec, .needVec,
    .strobe, .full, .allocIdx, .occupancy, .pendWb,
    .reqValid, .reqIdx, .reqReissue, .retireValid, .retireSeq
  );

  stq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk, .rstN, .strobe, .allocSeq, .allocAddr, .allocData,
    .rdIdx(reqIdx), .rdAddr(reqAddr), .rdData(reqData), .seqArr,
    .wbEnVec, .sentVec, .complVec, .reissVec, .needVec
  );
endmodule

// File: tb/tb_store_queue.sv
`timescale 1ns/100ps
module tb_store_queue;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, allocValid, squashValid, reqReady, respValid;
  logic [7:0] allocSeq, commitSeq, squashSeq;
  logic [AW-1:0] allocAddr;
  logic [DW-1:0] allocData;
  logic [1:0] allocIdx, reqIdx, respIdx;
  logic full, reqValid, reqReissue, retireValid;
  logic [AW-1:0] reqAddr;
  logic [DW-1:0] reqData;
  logic [7:0] retireSeq;
  logic [2:0] occupancy, pendWb;

  store_queue #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  task automatic chkEq(input string tag, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic respond(input logic [1:0] idx);
    respValid = 1'b1;
    respIdx   = idx;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; allocValid = 1'b0; squashValid = 1'b0; reqReady = 1'b0;
    respValid = 1'b0; allocSeq = '0; commitSeq = '0; squashSeq = '0;
    allocAddr = '0; allocData = '0; respIdx = '0;
    tick(); tick();
    rstN = 1'b1;
    #1;
    // Reset state (R1, R4, R5)
    chkEq("R1 reset occupancy", occupancy, 0);
    chkEq("R1 reset full", full, 0);
    chkEq("R4 reset pendWb", pendWb, 0);
    chkEq("R5 reset reqValid", reqValid, 0);
    chkEq("R9 reset retireValid", retireValid, 0);

    // R1: fill every slot
    for (int i = 0; i < 4; i++) begin
      allocValid = 1'b1;
      allocSeq = 8'(10 + i);
      allocAddr = AW'('h100 + i);
      allocData = DW'('hA0 + i);
      #1;
      chkEq("R1 allocIdx", allocIdx, i);
      tick();
    end
    allocValid = 1'b0;
    chkEq("R1 occupancy full", occupancy, 4);
    chkEq("R1 full flag", full, 1);
    allocValid = 1'b1; allocSeq = 8'd14;
    tick();
    allocValid = 1'b0;
    chkEq("R1 alloc ignored when full", occupancy, 4);

    // R2: commit ignored during squash and when zero
    commitSeq = 8'd11; squashValid = 1'b1; squashSeq = 8'd200;
    tick();
    commitSeq = '0; squashValid = 1'b0;
    chkEq("R2 commit blocked by squash", pendWb, 0);
    chkEq("R10 squash keeps older entries", occupancy, 4);
    tick();
    chkEq("R2 zero commit", pendWb, 0);

    // R3 / R5 / R6 / R4
    commitSeq = 8'd11;
    tick();
    commitSeq = '0;
    chkEq("R3 two marked", pendWb, 2);
    chkEq("R5 no request yet", reqValid, 0);
    tick();
    chkEq("R5 first req valid", reqValid, 1);
    chkEq("R5 first req idx", reqIdx, 0);
    chkEq("R5 first req kind", reqReissue, 0);
    chkEq("R5 first req addr", reqAddr, 'h100);
    chkEq("R5 first req data", reqData, 'hA0);
    repeat (3) tick();
    chkEq("R6 held valid", reqValid, 1);
    chkEq("R6 held idx", reqIdx, 0);
    chkEq("R4 held pend", pendWb, 2);
    reqReady = 1'b1;
    tick();
    reqReady = 1'b0;
    chkEq("R4 decrement on accept", pendWb, 1);
    chkEq("R5 next req idx", reqIdx, 1);
    chkEq("R5 next req addr", reqAddr, 'h101);
    reqReady = 1'b1;
    tick();
    chkEq("R4 drained", pendWb, 0);
    chkEq("R5 idle after sends", reqValid, 0);

    // R3: walk stops at younger seq
    commitSeq = 8'd12;
    tick();
    commitSeq = '0;
    chkEq("R3 stop at younger", pendWb, 1);
    tick();
    chkEq("R5 third req idx", reqIdx, 2);
    chkEq("R5 third req valid", reqValid, 1);
    tick();
    chkEq("R4 third accepted", pendWb, 0);
    chkEq("R5 idle again", reqValid, 0);
    commitSeq = 8'd12;
    tick();
    commitSeq = '0;
    chkEq("R3 no recount", pendWb, 0);

    // R7: non-head response only flags
    respond(2'd1);
    chkEq("R7 no retire on young resp", retireValid, 0);
    tick();
    respValid = 1'b0;
    chkEq("R7 no request after young resp", reqValid, 0);
    tick();
    chkEq("R7 still no request", reqValid, 0);
    chkEq("R7 occupancy kept", occupancy, 4);

    // R8: head response triggers a second send
    respond(2'd0);
    chkEq("R8 no retire on first head resp", retireValid, 0);
    tick();
    respValid = 1'b0;
    chkEq("R8 not yet requested", reqValid, 0);
    tick();
    chkEq("R8 reissue valid", reqValid, 1);
    chkEq("R8 reissue idx", reqIdx, 0);
    chkEq("R8 reissue kind", reqReissue, 1);
    chkEq("R8 reissue addr", reqAddr, 'h100);
    tick();
    chkEq("R8 reissue accepted", reqValid, 0);

    // R9: second response retires
    respond(2'd0);
    chkEq("R9 retire valid", retireValid, 1);
    chkEq("R9 retire seq", retireSeq, 10);
    tick();
    respValid = 1'b0;
    chkEq("R9 occupancy drop", occupancy, 3);
    tick();
    chkEq("R7 pass sets need only", reqValid, 0);
    tick();
    chkEq("R7 head reissue valid", reqValid, 1);
    chkEq("R7 head reissue idx", reqIdx, 1);
    chkEq("R7 head reissue kind", reqReissue, 1);
    tick();
    respond(2'd1);
    chkEq("R9 retire second", retireValid, 1);
    chkEq("R9 retire seq second", retireSeq, 11);
    tick();
    respValid = 1'b0;
    chkEq("R9 occupancy two", occupancy, 2);

    // R8 priority over a fresh first send
    respValid = 1'b1; respIdx = 2'd2; commitSeq = 8'd13;
    tick();
    respValid = 1'b0; commitSeq = '0;
    chkEq("R3 mark last", pendWb, 1);
    tick();
    chkEq("R8 priority idx", reqIdx, 2);
    chkEq("R8 priority kind", reqReissue, 1);
    tick();
    chkEq("R5 after reissue idx", reqIdx, 3);
    chkEq("R5 after reissue kind", reqReissue, 0);
    chkEq("R5 after reissue data", reqData, 'hA3);
    chkEq("R4 reissue no decrement", pendWb, 1);
    tick();
    chkEq("R4 last accepted", pendWb, 0);
    respond(2'd2);
    chkEq("R9 retire third seq", retireSeq, 12);
    chkEq("R9 retire third", retireValid, 1);
    tick();
    respValid = 1'b0;
    chkEq("R9 occupancy one", occupancy, 1);

    // R10: squash over a wrapped head
    for (int i = 0; i < 3; i++) begin
      allocValid = 1'b1;
      allocSeq = 8'(20 + i);
      allocAddr = AW'('h200 + i);
      allocData = DW'('hB0 + i);
      #1;
      chkEq("R1 wrapped allocIdx", allocIdx, i);
      tick();
    end
    allocValid = 1'b0;
    chkEq("R1 full again", full, 1);
    squashValid = 1'b1; squashSeq = 8'd20;
    allocValid = 1'b1; allocSeq = 8'd99; commitSeq = 8'd22;
    tick();
    squashValid = 1'b0; allocValid = 1'b0; commitSeq = '0;
    chkEq("R10 drop young", occupancy, 2);
    chkEq("R10 tail moves back", allocIdx, 1);
    chkEq("R2 commit ignored in squash", pendWb, 0);
    squashValid = 1'b1; squashSeq = 8'd5;
    tick();
    squashValid = 1'b0;
    chkEq("R10 committed entry stays", occupancy, 1);

    // Drain the last committed store
    respond(2'd3);
    tick();
    respValid = 1'b0;
    tick();
    chkEq("R8 last reissue idx", reqIdx, 3);
    chkEq("R8 last reissue kind", reqReissue, 1);
    tick();
    respond(2'd3);
    chkEq("R9 last retire seq", retireSeq, 13);
    tick();
    respValid = 1'b0;
    chkEq("R9 empty", occupancy, 0);
    chkEq("R1 not full", full, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule